// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Decode

This block fetches instructions that are either one or two halfwords long. A halfword read bus carries the reads. The block keeps the program counter. It issues a read at the program counter, looks at the opcode in the returned halfword to decide whether a second read is needed, and assembles a 32-bit instruction word. It then splits that word into register indices, an immediate, a displacement, a condition code and a sub-opcode, according to one of seven field layouts. It also raises an illegal-encoding flag for the encodings that are not allowed.

The decoded instruction is presented with a valid signal and held until the execution side accepts it. On acceptance the program counter moves past the instruction and the next fetch begins. A flush input redirects fetching to a new address. It throws away a half-built instruction and any read response still in flight. The execution side raises the flush on a taken jump or on exception entry.

Top module: `vlfd_top`

## Requirements
- R1: After reset, the program counter equals RESET_PC (default 0), `dec_valid` is 0, and a read request to RESET_PC is presented in the first cycle after reset is released.
- R2: Each read request lasts exactly one cycle and targets PC for the first halfword and PC+2 for the second. No further request is issued until the response to the outstanding one has arrived.
- R3: The opcode is bits 15:10 of the first halfword, which become bits 31:26 of the assembled word. The opcode picks the format as follows: 0–15 format 1, 16–31 format 2, 32–39 format 3, 40–43 format 4, 44–47 format 7, 48–59 format 5, 60–63 format 6. Formats 1–3 are one halfword, with bits 15:0 of the word zero and `dec_long`=0. Formats 4–7 are two halfwords, the second filling bits 15:0, with `dec_long`=1.
- R4: Format 1 gives reg2 from word bits 25:21 and reg1 from bits 20:16. Format 2 gives reg2 from bits 25:21 and a 5-bit immediate from bits 20:16. That immediate is sign-extended for opcodes 16–23 and zero-extended for opcodes 24–31. Fields that a format does not define read as 0.
- R5: Format 3 gives the condition from bits 28:25 and a displacement that sign-extends the 9-bit value in bits 24:16.
- R6: Format 4 sign-extends bits 25:0 into the displacement. Format 5 gives reg2 and reg1 as in format 1 and a 16-bit immediate from bits 15:0. That immediate is sign-extended for opcodes 48–55 and zero-extended for opcodes 56–59. Format 6 gives reg2 and reg1 and sign-extends bits 15:0 into the displacement.
- R7: Format 7 gives reg2 and reg1 and a sub-opcode from bits 15:10. `dec_illegal` is 1 exactly when the sub-opcode is 16 or more.
- R8: For opcode 31, the bit-string group of format 2, `dec_illegal` is 1 exactly when the 5-bit field is 16 or more. No other opcode of formats 1–6 is flagged.
- R9: While `dec_valid` is 1 and `dec_ready` is 0, the decoded outputs and `dec_pc` stay unchanged and no read request is issued.
- R10: When an instruction is accepted (`dec_valid` and `dec_ready`), the program counter advances by 2 for a short instruction or by 4 for a long one, and the next fetch starts there.
- R11: `flush` loads the program counter from `flush_pc` and clears `dec_valid` in the next cycle. It restarts at the first halfword, and it drops the response of a read that was outstanding when the flush arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Redirect fetch to `flush_pc`, discarding partial work |
| flush_pc | input | ADDR_W | New fetch address |
| rd_req | output | 1 | Halfword read request, one cycle |
| rd_addr | output | ADDR_W | Read address |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 16 | Returned halfword |
| dec_valid | output | 1 | Decoded instruction available |
| dec_ready | input | 1 | Execution accepts the instruction |
| dec_pc | output | ADDR_W | Address of the decoded instruction |
| dec_word | output | 32 | Assembled instruction word |
| dec_fmt | output | 3 | Format number 1–7 |
| dec_long | output | 1 | Instruction is two halfwords |
| dec_opcode | output | 6 | Opcode |
| dec_reg2 | output | 5 | reg2 index |
| dec_reg1 | output | 5 | reg1 index |
| dec_cond | output | 4 | Branch condition |
| dec_subop | output | 6 | Sub-opcode |
| dec_imm | output | 32 | Extended immediate |
| dec_disp | output | 32 | Sign-extended displacement |
| dec_illegal | output | 1 | Illegal encoding |

## Verification
A request appears combinationally in the cycle the fetch stage is ready, so it is sampled on the falling edge of that same cycle. A response captured at a rising edge makes `dec_valid` and all decoded fields visible right after that edge, and `flush` or acceptance changes the program counter one edge later. The bench drives inputs and samples outputs only on falling edges. It waits for `dec_valid` before reading fields, and it logs every request address in the responder so that read ordering and the absence of requests can be checked exactly. The responder latency is varied, and one flush is placed while a second-halfword read is outstanding to exercise the discard path.

// File: rtl/vlfd_pkg.sv
// Shared types and opcode classification for the fetch/decode block.
// Assumes a 6-bit opcode in the top bits of the first halfword.
package vlfd_pkg;

    localparam int HW_W   = 16;
    localparam int WORD_W = 2 * HW_W;

    typedef enum logic [1:0] {
        S_ISSUE = 2'd0,
        S_WAIT  = 2'd1,
        S_HOLD  = 2'd2
    } fetch_st_e;

    typedef struct packed {
        logic [2:0]        fmt;
        logic              long_ins;
        logic [5:0]        opcode;
        logic [4:0]        reg2;
        logic [4:0]        reg1;
        logic [3:0]        cond;
        logic [5:0]        subop;
        logic [WORD_W-1:0] imm;
        logic [WORD_W-1:0] disp;
        logic              illegal;
    } dec_t;

    // Map an opcode onto its field layout number (1..7)
    function automatic logic [2:0] fmt_of(input logic [5:0] op);
        logic [2:0] f;
        if (op[5:4] == 2'b00)        f = 3'd1;
        else if (op[5:4] == 2'b01)   f = 3'd2;
        else if (op[5:3] == 3'b100)  f = 3'd3;
        else if (op[5:2] == 4'b1010) f = 3'd4;
        else if (op[5:2] == 4'b1011) f = 3'd7;
        else if (op[5:3] == 3'b110)  f = 3'd5;
        else if (op[5:2] == 4'b1110) f = 3'd5;
        else                         f = 3'd6;
        return f;
    endfunction

endpackage

// File: rtl/vlfd_fetch.sv
// Fetch sequencer: issues halfword reads at PC (+2 for the second unit),
// assembles the instruction word, holds it until accepted, advances PC.
// Assumes at most one read outstanding; responses arrive in order.
module vlfd_fetch
    import vlfd_pkg::*;
#(
    parameter int               ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_pc,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_rsp_valid,
    input  logic [HW_W-1:0]   rd_rsp_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_pc,
    output logic [WORD_W-1:0] out_word
);

    localparam logic [ADDR_W-1:0] STEP_SHORT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP_LONG  = ADDR_W'(4);

    fetch_st_e          st;
    logic [ADDR_W-1:0]  pc;
    logic               unit;
    logic               drop;
    logic               long_q;
    logic [HW_W-1:0]    hi;
    logic [WORD_W-1:0]  word;
    logic               first_long;

    // Length of the instruction whose first halfword is arriving
    assign first_long = (fmt_of(rd_rsp_data[15:10]) >= 3'd4);

    // Request only from the issue state, never during a flush or stale wait
    assign rd_req    = (st == S_ISSUE) && !drop && !flush;
    assign rd_addr   = unit ? (pc + STEP_SHORT) : pc;
    assign out_valid = (st == S_HOLD);
    assign out_pc    = pc;
    assign out_word  = word;

    // Fetch state, PC, unit index and assembly registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_ISSUE;
            pc     <= RESET_PC;
            unit   <= 1'b0;
            drop   <= 1'b0;
            long_q <= 1'b0;
            hi     <= '0;
            word   <= '0;
        end else if (flush) begin
            pc     <= flush_pc;
            unit   <= 1'b0;
            st     <= S_ISSUE;
            drop   <= rd_rsp_valid ? 1'b0 : (drop || (st == S_WAIT));
        end else begin
            case (st)
                S_ISSUE: begin
                    if (drop) begin
                        if (rd_rsp_valid) drop <= 1'b0;
                    end else begin
                        st <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (rd_rsp_valid) begin
                        if (!unit && first_long) begin
                            hi     <= rd_rsp_data;
                            unit   <= 1'b1;
                            st     <= S_ISSUE;
                        end else begin
                            word   <= unit ? {hi, rd_rsp_data} : {rd_rsp_data, {HW_W{1'b0}}};
                            long_q <= unit;
                            unit   <= 1'b0;
                            st     <= S_HOLD;
                        end
                    end
                end
                S_HOLD: begin
                    if (out_ready) begin
                        pc <= pc + (long_q ? STEP_LONG : STEP_SHORT);
                        st <= S_ISSUE;
                    end
                end
                default: st <= S_ISSUE;
            endcase
        end
    end

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R2
    req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[0] == 1'b0));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(pc) && $stable(word)));

    // R10
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !flush) |=>
            (pc == $past(pc) + ($past(long_q) ? STEP_LONG : STEP_SHORT)));

    // R11
    flush_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!out_valid && pc == $past(flush_pc) && !unit));

endmodule

// File: rtl/vlfd_decode.sv
// Combinational field extractor: splits an assembled word into fields per
// its format, applies per-opcode extension and flags illegal encodings.
// Assumes the word holds the first halfword in bits 31:16.
module vlfd_decode
    import vlfd_pkg::*;
#(
    parameter logic [5:0] BITSTR_OP   = 6'd31,
    parameter int         SUBOP_LIMIT = 16
) (
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);

    logic [4:0] field5;
    assign field5 = word[20:16];

    // Decode every field according to the layout chosen by the opcode
    always_comb begin
        dec          = '0;
        dec.opcode   = word[31:26];
        dec.fmt      = fmt_of(word[31:26]);
        dec.long_ins = (dec.fmt >= 3'd4);
        case (dec.fmt)
            3'd1: begin
                dec.reg2 = word[25:21];
                dec.reg1 = word[20:16];
            end
            3'd2: begin
                dec.reg2    = word[25:21];
                dec.imm     = word[29] ? {27'b0, field5} : {{27{field5[4]}}, field5};
                dec.illegal = (word[31:26] == BITSTR_OP) && (field5 >= 5'(SUBOP_LIMIT));
            end
            3'd3: begin
                dec.cond = word[28:25];
                dec.disp = {{23{word[24]}}, word[24:16]};
            end
            3'd4: begin
                dec.disp = {{6{word[25]}}, word[25:0]};
            end
            3'd5: begin
                dec.reg2 = word[25:21];
                dec.reg1 = word[20:16];
                dec.imm  = word[29] ? {16'b0, word[15:0]} : {{16{word[15]}}, word[15:0]};
            end
            3'd6: begin
                dec.reg2 = word[25:21];
                dec.reg1 = word[20:16];
                dec.disp = {{16{word[15]}}, word[15:0]};
            end
            default: begin
                dec.reg2    = word[25:21];
                dec.reg1    = word[20:16];
                dec.subop   = word[15:10];
                dec.illegal = (word[15:10] >= 6'(SUBOP_LIMIT));
            end
        endcase
    end

endmodule

// File: rtl/vlfd_top.sv
// Top of the variable-length fetch/decode block: connects the fetch
// sequencer to the field decoder and exposes the decoded instruction.
// Assumes the execution side raises flush on any redirect.
module vlfd_top
    import vlfd_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_pc,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_rsp_valid,
    input  logic [15:0]       rd_rsp_data,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [ADDR_W-1:0] dec_pc,
    output logic [31:0]       dec_word,
    output logic [2:0]        dec_fmt,
    output logic              dec_long,
    output logic [5:0]        dec_opcode,
    output logic [4:0]        dec_reg2,
    output logic [4:0]        dec_reg1,
    output logic [3:0]        dec_cond,
    output logic [5:0]        dec_subop,
    output logic [31:0]       dec_imm,
    output logic [31:0]       dec_disp,
    output logic              dec_illegal
);

    logic [WORD_W-1:0] word;
    dec_t              d;

    vlfd_fetch #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .flush_pc     (flush_pc),
        .rd_req       (rd_req),
        .rd_addr      (rd_addr),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .out_ready    (dec_ready),
        .out_valid    (dec_valid),
        .out_pc       (dec_pc),
        .out_word     (word)
    );

    vlfd_decode u_dec (
        .word (word),
        .dec  (d)
    );

    assign dec_word    = word;
    assign dec_fmt     = d.fmt;
    assign dec_long    = d.long_ins;
    assign dec_opcode  = d.opcode;
    assign dec_reg2    = d.reg2;
    assign dec_reg1    = d.reg1;
    assign dec_cond    = d.cond;
    assign dec_subop   = d.subop;
    assign dec_imm     = d.imm;
    assign dec_disp    = d.disp;
    assign dec_illegal = d.illegal;

    // R3
    long_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_long) |-> (dec_word[15:0] == 16'h0000));

endmodule

// File: tb/vlfd_top_test.sv
`timescale 1ns/1ps
module vlfd_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] flush_pc = '0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [15:0] rd_rsp_data = '0;
    logic        dec_valid;
    logic        dec_ready = 1'b0;
    logic [31:0] dec_pc, dec_word, dec_imm, dec_disp;
    logic [2:0]  dec_fmt;
    logic        dec_long, dec_illegal;
    logic [5:0]  dec_opcode, dec_subop;
    logic [4:0]  dec_reg2, dec_reg1;
    logic [3:0]  dec_cond;

    int total = 0;
    int bad = 0;
    int lat = 1;
    logic [15:0] mem [0:63];
    logic [31:0] req_log [0:15];
    int req_n = 0;

    always #2.5 clk = ~clk;

    vlfd_top uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_pc(flush_pc),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_pc(dec_pc),
        .dec_word(dec_word), .dec_fmt(dec_fmt), .dec_long(dec_long),
        .dec_opcode(dec_opcode), .dec_reg2(dec_reg2), .dec_reg1(dec_reg1),
        .dec_cond(dec_cond), .dec_subop(dec_subop), .dec_imm(dec_imm),
        .dec_disp(dec_disp), .dec_illegal(dec_illegal)
    );

    // Memory responder: one response lat cycles after each request
    initial begin
        logic seen;
        logic [31:0] a, pa;
        int cnt;
        logic pend;
        pend = 1'b0; cnt = 0; pa = '0;
        forever begin
            @(posedge clk);
            seen = rd_req && rst_n;
            a = rd_addr;
            @(negedge clk);
            rd_rsp_valid = 1'b0;
            if (pend) begin
                cnt = cnt - 1;
                if (cnt <= 0) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = mem[pa[6:1]];
                    pend = 1'b0;
                end
            end
            if (seen === 1'b1) begin
                pend = 1'b1; cnt = lat; pa = a;
                if (req_n < 16) req_log[req_n] = a;
                req_n = req_n + 1;
            end
        end
    end

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic wait_valid(input string r);
        int n;
        n = 0;
        while (dec_valid !== 1'b1 && n < 100) begin
            @(negedge clk);
            n++;
        end
        check({r, " valid"}, {31'b0, dec_valid}, 32'd1);
    endtask

    task automatic go_to(input logic [31:0] a);
        @(negedge clk);
        req_n = 0;
        flush = 1'b1; flush_pc = a;
        @(negedge clk);
        flush = 1'b0;
        check("R11 valid cleared", {31'b0, dec_valid}, 32'd0);
    endtask

    task automatic accept();
        @(negedge clk);
        dec_ready = 1'b1;
        @(negedge clk);
        dec_ready = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 valid", {31'b0, dec_valid}, 32'd0);
        check("R1 req", {31'b0, rd_req}, 32'd1);
        check("R1 addr", rd_addr, 32'h0);
        wait_valid("R1");
        check("R1 pc", dec_pc, 32'h0);
        check("R1 fmt", {29'b0, dec_fmt}, 32'd1);
    endtask

    task automatic t_fmt1();
        mem[8] = 16'h1467;
        go_to(32'h10);
        wait_valid("R4");
        check("R3 word", dec_word, 32'h14670000);
        check("R3 long", {31'b0, dec_long}, 32'd0);
        check("R3 opcode", {26'b0, dec_opcode}, 32'd5);
        check("R4 fmt", {29'b0, dec_fmt}, 32'd1);
        check("R4 reg2", {27'b0, dec_reg2}, 32'd3);
        check("R4 reg1", {27'b0, dec_reg1}, 32'd7);
        check("R4 imm zero", dec_imm, 32'h0);
        check("R2 one read", req_n, 32'd1);
        check("R2 addr", req_log[0], 32'h10);
    endtask

    task automatic t_fmt2();
        mem[16] = 16'h453C;
        mem[17] = 16'h645C;
        go_to(32'h20);
        wait_valid("R4");
        check("R4 fmt2", {29'b0, dec_fmt}, 32'd2);
        check("R4 signed imm", dec_imm, 32'hFFFFFFFC);
        check("R4 reg2", {27'b0, dec_reg2}, 32'd9);
        check("R4 reg1 zero", {27'b0, dec_reg1}, 32'd0);
        accept();
        wait_valid("R10");
        check("R10 pc+2", dec_pc, 32'h22);
        check("R4 unsigned imm", dec_imm, 32'd28);
        check("R4 reg2 b", {27'b0, dec_reg2}, 32'd2);
    endtask

    task automatic t_bitstr();
        mem[24] = 16'h7C14;
        mem[25] = 16'h7C0F;
        go_to(32'h30);
        wait_valid("R8");
        check("R8 illegal field 20", {31'b0, dec_illegal}, 32'd1);
        accept();
        wait_valid("R8");
        check("R8 legal field 15", {31'b0, dec_illegal}, 32'd0);
        check("R8 imm", dec_imm, 32'd15);
    endtask

    task automatic t_branch();
        mem[28] = 16'h97F0;
        go_to(32'h38);
        wait_valid("R5");
        check("R5 fmt", {29'b0, dec_fmt}, 32'd3);
        check("R5 cond", {28'b0, dec_cond}, 32'hB);
        check("R5 disp", dec_disp, 32'hFFFFFFF0);
        check("R5 long", {31'b0, dec_long}, 32'd0);
    endtask

    task automatic t_long();
        lat = 3;
        mem[32] = 16'hA600; mem[33] = 16'h0004;
        mem[34] = 16'hC822; mem[35] = 16'h8001;
        mem[36] = 16'hE485; mem[37] = 16'h8001;
        mem[38] = 16'hF4C8; mem[39] = 16'hFFFE;
        go_to(32'h40);
        wait_valid("R6");
        check("R3 two reads", req_n, 32'd2);
        check("R2 first addr", req_log[0], 32'h40);
        check("R2 second addr", req_log[1], 32'h42);
        check("R3 word", dec_word, 32'hA6000004);
        check("R3 long", {31'b0, dec_long}, 32'd1);
        check("R6 fmt4", {29'b0, dec_fmt}, 32'd4);
        check("R6 disp26", dec_disp, 32'hFE000004);
        accept();
        wait_valid("R6");
        check("R10 pc+4", dec_pc, 32'h44);
        check("R6 fmt5", {29'b0, dec_fmt}, 32'd5);
        check("R6 signed imm16", dec_imm, 32'hFFFF8001);
        check("R6 reg2", {27'b0, dec_reg2}, 32'd1);
        check("R6 reg1", {27'b0, dec_reg1}, 32'd2);
        accept();
        wait_valid("R6");
        check("R6 unsigned imm16", dec_imm, 32'h00008001);
        check("R6 reg1 b", {27'b0, dec_reg1}, 32'd5);
        accept();
        wait_valid("R6");
        check("R6 fmt6", {29'b0, dec_fmt}, 32'd6);
        check("R6 disp16", dec_disp, 32'hFFFFFFFE);
        check("R6 reg2 c", {27'b0, dec_reg2}, 32'd6);
        check("R6 reg1 c", {27'b0, dec_reg1}, 32'd8);
        lat = 1;
    endtask

    task automatic t_fmt7();
        mem[40] = 16'hB94B; mem[41] = 16'h0C00;
        mem[42] = 16'hB94B; mem[43] = 16'h4000;
        go_to(32'h50);
        wait_valid("R7");
        check("R7 fmt", {29'b0, dec_fmt}, 32'd7);
        check("R7 subop", {26'b0, dec_subop}, 32'd3);
        check("R7 legal", {31'b0, dec_illegal}, 32'd0);
        check("R7 reg2", {27'b0, dec_reg2}, 32'd10);
        check("R7 reg1", {27'b0, dec_reg1}, 32'd11);
        accept();
        wait_valid("R7");
        check("R7 subop 16", {26'b0, dec_subop}, 32'd16);
        check("R7 illegal", {31'b0, dec_illegal}, 32'd1);
    endtask

    task automatic t_hold();
        int n0;
        logic [31:0] w0;
        n0 = req_n;
        w0 = dec_word;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R9 valid held", {31'b0, dec_valid}, 32'd1);
        end
        check("R9 word held", dec_word, w0);
        check("R9 pc held", dec_pc, 32'h54);
        check("R9 no request", req_n, n0);
    endtask

    task automatic t_flush();
        int n;
        lat = 6;
        mem[48] = 16'hA600; mem[49] = 16'h0004;
        mem[52] = 16'h1467;
        go_to(32'h60);
        n = 0;
        while (req_n < 2 && n < 100) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        flush = 1'b1; flush_pc = 32'h68;
        @(negedge clk);
        flush = 1'b0;
        check("R11 valid low", {31'b0, dec_valid}, 32'd0);
        wait_valid("R11");
        check("R11 word", dec_word, 32'h14670000);
        check("R11 pc", dec_pc, 32'h68);
        check("R11 long", {31'b0, dec_long}, 32'd0);
        check("R11 restart unit 0", req_log[2], 32'h68);
        lat = 1;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fmt1();
        t_fmt2();
        t_bitstr();
        t_branch();
        t_long();
        t_fmt7();
        t_hold();
        t_flush();
        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule